// File: doc/BRIEF.md
# ADC Conversion Control Register Unit

This unit is the byte-wide control and status register of a successive-approximation converter. A single control byte does several jobs. It picks which of five start sources begins a conversion. It sets the divide ratio that turns the system clock into a conversion clock-enable. It chooses how the 12-bit result is packed into two readable data bytes. It also holds the conversion-complete interrupt flag.

A conversion starts on the rising edge of the selected source, and only while no conversion is running. The converter answers with a one-cycle done pulse and a 12-bit value. On that pulse the unit captures the value and raises the interrupt flag. Software clears the flag by writing zero to it, or hardware clears it with an acknowledge pulse. The data bytes are served from the one captured value, so a read never mixes two conversions.

Top module: `adc_ctl_unit`

## Requirements
- R1: After reset the control byte at address 0x9D reads 0x01, both data bytes (high at 0x9E, low at 0x9F) read 0x00, and `irq` is low.
- R2: Control bits 6:0 read back exactly as last written. Bit 6 is reference select, bits 5:3 are the start source code, bit 2 is alignment, and bits 1:0 are the divide code.
- R3: A `conv_done` pulse sets the flag, which is control bit 7 and drives `irq`, in the next cycle. Writing 1 to bit 7 leaves the flag unchanged.
- R4: The flag clears after a control write with bit 7 = 0, or after an `int_ack` pulse. If `conv_done` arrives in the same cycle as either clear, the flag is set.
- R5: Start source code 0 selects `trig_soft`, 1 selects `trig_timer1`, 2 selects `trig_timer3`, 3 selects `trig_ext_irq` and 4 selects `trig_ext0`. `conv_start` pulses in the same cycle that the selected source first goes high while the unit is idle. Unselected sources cause no start.
- R6: Start source codes 5, 6 and 7 never produce `conv_start`.
- R7: A start marks the unit busy until `conv_done` arrives. Rising edges seen while busy produce no `conv_start`.
- R8: With alignment 0, the high byte holds result bits 11:4 and the low byte holds result bits 3:0 in its bits 7:4, with zeros below.
- R9: With alignment 1, the high byte holds result bits 11:8 in its bits 3:0, with zeros above, and the low byte holds result bits 7:0.
- R10: `conv_clk_en` pulses once every 2^D cycles, where D is the divide code. Every control write restarts the count. In cycle k after the write edge (k = 0 first), the pulse is high when k mod 2^D = 2^D − 1.
- R11: The data bytes change only on `conv_done`. A changing `conv_value` without a done pulse does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, 0 when unmapped |
| trig_soft | input | 1 | Software start request |
| trig_timer1 | input | 1 | First timer match |
| trig_timer3 | input | 1 | Third timer match |
| trig_ext_irq | input | 1 | External interrupt line A |
| trig_ext0 | input | 1 | External interrupt line 0 |
| int_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| conv_done | input | 1 | One-cycle conversion complete pulse from the converter |
| conv_value | input | 12 | Conversion result, valid with conv_done |
| conv_start | output | 1 | One-cycle conversion start request |
| conv_clk_en | output | 1 | Prescaled conversion clock-enable |
| irq | output | 1 | Interrupt flag |

## Verification
Several properties are checked on every cycle. A done pulse must be followed by a raised flag. Writing one to the flag must not move it, and an acknowledge without a done must leave the flag clear. The unused source codes must never start a conversion. Divide-by-one must keep the enable high, and the captured result must not change without a done pulse. Other behaviours need the bench's scenarios: the mapping from each source code to its input, the blocking of triggers while busy, the bit placement in both alignments, and the prescaler phase after a restart.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    localparam int RES_W    = 12;
    localparam int SRC_N    = 5;
    localparam int SRC_SELW = 3;
    localparam int DIV_SELW = 2;

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [RES_W-1:0] raw;
        logic             busy;
    } adc_state_t;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
    parameter int N_SRC = 5,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             rise
);
    localparam int SPAN = 1 << SEL_W;

    logic [N_SRC-1:0] prev_d, prev_q;
    logic [N_SRC-1:0] edge_v;
    logic [SPAN-1:0]  edge_pad;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_edge
            assign edge_v[g] = src[g] & ~prev_q[g];
        end
    endgenerate

    always_comb begin
        prev_d   = src;
        edge_pad = '0;
        edge_pad[N_SRC-1:0] = edge_v;
        rise     = edge_pad[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             clk_en
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(sel)) limit[i] = 1'b1;
        end
        clk_en = (cnt_q == limit);
        if (restart)     cnt_d = '0;
        else if (clk_en) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
    import adc_ctl_pkg::*;
(
    input  logic [RES_W-1:0] raw,
    input  logic             align_lsb,
    output logic [7:0]       hi_byte,
    output logic [7:0]       lo_byte
);
    always_comb begin
        if (align_lsb) begin
            hi_byte = {4'h0, raw[11:8]};
            lo_byte = raw[7:0];
        end else begin
            hi_byte = raw[11:4];
            lo_byte = {raw[3:0], 4'h0};
        end
    end
endmodule

// File: rtl/adc_ctl_unit.sv
module adc_ctl_unit
    import adc_ctl_pkg::*;
#(
    parameter logic [7:0] ADDR_CTRL  = 8'h9D,
    parameter logic [7:0] ADDR_DHI   = 8'h9E,
    parameter logic [7:0] ADDR_DLO   = 8'h9F,
    parameter logic [7:0] CTRL_RESET = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_we,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             trig_soft,
    input  logic             trig_timer1,
    input  logic             trig_timer3,
    input  logic             trig_ext_irq,
    input  logic             trig_ext0,
    input  logic             int_ack,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_value,
    output logic             conv_start,
    output logic             conv_clk_en,
    output logic             irq
);
    localparam int FLAG_BIT = 7;

    adc_state_t state_d, state_q;

    logic [7:0]       ctrl_q;
    logic [RES_W-1:0] raw_q;
    logic             wr_ctrl;
    logic             src_rise;
    logic [7:0]       hi_byte, lo_byte;
    logic [SRC_N-1:0] src_vec;

    assign ctrl_q  = state_q.ctrl;
    assign raw_q   = state_q.raw;
    assign src_vec = {trig_ext0, trig_ext_irq, trig_timer3, trig_timer1, trig_soft};
    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);

    adc_trig_sel #(.N_SRC(SRC_N), .SEL_W(SRC_SELW)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_vec),
        .sel   (ctrl_q[5:3]),
        .rise  (src_rise)
    );

    adc_clk_div #(.SEL_W(DIV_SELW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ctrl_q[DIV_SELW-1:0]),
        .restart (wr_ctrl),
        .clk_en  (conv_clk_en)
    );

    adc_result_fmt u_fmt (
        .raw       (raw_q),
        .align_lsb (ctrl_q[2]),
        .hi_byte   (hi_byte),
        .lo_byte   (lo_byte)
    );

    always_comb begin
        conv_start = src_rise && !state_q.busy;
        state_d    = state_q;
        if (wr_ctrl) begin
            state_d.ctrl[FLAG_BIT-1:0] = bus_wdata[FLAG_BIT-1:0];
            if (!bus_wdata[FLAG_BIT]) state_d.ctrl[FLAG_BIT] = 1'b0;
        end
        if (int_ack) state_d.ctrl[FLAG_BIT] = 1'b0;
        if (conv_done) begin
            state_d.ctrl[FLAG_BIT] = 1'b1;
            state_d.raw            = conv_value;
            state_d.busy           = 1'b0;
        end
        if (conv_start) state_d.busy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl <= CTRL_RESET;
            state_q.raw  <= '0;
            state_q.busy <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_DHI:  bus_rdata = hi_byte;
            ADDR_DLO:  bus_rdata = lo_byte;
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign irq = ctrl_q[FLAG_BIT];
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
    parameter logic [7:0] ADDR_CTRL = 8'h9D
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_we,
    input logic [7:0]  bus_wdata,
    input logic        int_ack,
    input logic        conv_done,
    input logic        conv_start,
    input logic        conv_clk_en,
    input logic        irq,
    input logic [7:0]  ctrl_q,
    input logic [11:0] raw_q
);
    logic one_write;
    assign one_write = bus_we && (bus_addr == ADDR_CTRL) && bus_wdata[7];

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> irq);

    assert_one_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (one_write && !conv_done && !int_ack) |=> (irq == $past(irq)));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !conv_done) |=> !irq);

    assert_unused_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[5:3] > 3'd4) |-> !conv_start);

    assert_div1_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b00) |-> conv_clk_en);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(raw_q));
endmodule

bind adc_ctl_unit adc_ctl_chk #(.ADDR_CTRL(ADDR_CTRL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .int_ack     (int_ack),
    .conv_done   (conv_done),
    .conv_start  (conv_start),
    .conv_clk_en (conv_clk_en),
    .irq         (irq),
    .ctrl_q      (ctrl_q),
    .raw_q       (raw_q)
);

// File: tb/tb_adc_ctl_unit.sv
`timescale 1ns/1ps
module tb_adc_ctl_unit;
    localparam logic [7:0] A_CTRL = 8'h9D;
    localparam logic [7:0] A_DHI  = 8'h9E;
    localparam logic [7:0] A_DLO  = 8'h9F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [4:0]  trg = '0;
    logic        int_ack = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_value = '0;
    logic        conv_start, conv_clk_en, irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_ctl_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_soft(trg[0]), .trig_timer1(trg[1]), .trig_timer3(trg[2]),
        .trig_ext_irq(trg[3]), .trig_ext0(trg[4]),
        .int_ack(int_ack), .conv_done(conv_done), .conv_value(conv_value),
        .conv_start(conv_start), .conv_clk_en(conv_clk_en), .irq(irq)
    );

    function automatic logic [7:0] exp_hi(logic [11:0] v, logic al);
        return al ? {4'h0, v[11:8]} : v[11:4];
    endfunction
    function automatic logic [7:0] exp_lo(logic [11:0] v, logic al);
        return al ? v[7:0] : {v[3:0], 4'h0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic done_pulse(logic [11:0] v);
        @(negedge clk);
        conv_done = 1'b1; conv_value = v;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // pulse one source for one cycle; return whether conv_start rose
    task automatic pulse_src(int idx, output logic st);
        @(negedge clk);
        trg[idx] = 1'b1; #1; st = conv_start;
        @(negedge clk);
        trg[idx] = 1'b0;
    endtask

    initial begin
        logic [7:0] r, h, l;
        logic st;
        logic [11:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTRL, r); check("R1 ctrl", r, 8'h01);
        rd(A_DHI, r);  check("R1 dhi", r, 8'h00);
        rd(A_DLO, r);  check("R1 dlo", r, 8'h00);
        check("R1 irq", irq, 1'b0);

        // R2 random readback
        for (int i = 0; i < 10; i++) begin
            logic [7:0] d;
            d = 8'($urandom());
            wr(A_CTRL, d);
            rd(A_CTRL, r);
            check("R2 readback", r[6:0], d[6:0]);
        end
        wr(A_CTRL, 8'h01);

        // R5 source mapping
        for (int c = 0; c < 5; c++) begin
            wr(A_CTRL, {5'(c), 3'b001});
            for (int s = 0; s < 5; s++) begin
                pulse_src(s, st);
                check("R5 source map", st, (s == c));
                if (st) done_pulse(12'h000);
            end
        end

        // R6 unused codes
        for (int c = 5; c < 8; c++) begin
            wr(A_CTRL, {5'(c), 3'b001});
            for (int s = 0; s < 5; s++) begin
                pulse_src(s, st);
                check("R6 unused code", st, 1'b0);
            end
        end

        // R7 busy blocking
        wr(A_CTRL, {5'd1, 3'b001});
        pulse_src(1, st); check("R7 first start", st, 1'b1);
        pulse_src(1, st); check("R7 blocked while busy", st, 1'b0);
        done_pulse(12'h5A5);
        pulse_src(1, st); check("R7 start after done", st, 1'b1);
        done_pulse(12'h000);

        // R3 / R8 / R9 random results
        wr(A_CTRL, 8'h01);
        for (int i = 0; i < 12; i++) begin
            v = 12'($urandom());
            done_pulse(v);
            check("R3 flag set", irq, 1'b1);
            wr(A_CTRL, 8'h81);
            check("R3 write one no effect", irq, 1'b1);
            rd(A_DHI, h); rd(A_DLO, l);
            check("R8 msb hi", h, exp_hi(v, 1'b0));
            check("R8 msb lo", l, exp_lo(v, 1'b0));
            wr(A_CTRL, 8'h85);
            rd(A_DHI, h); rd(A_DLO, l);
            check("R9 lsb hi", h, exp_hi(v, 1'b1));
            check("R9 lsb lo", l, exp_lo(v, 1'b1));
            wr(A_CTRL, 8'h01);
            check("R4 write zero clears", irq, 1'b0);
        end
        // corner values
        done_pulse(12'hFFF);
        rd(A_DHI, h); rd(A_DLO, l);
        check("R8 all ones hi", h, 8'hFF); check("R8 all ones lo", l, 8'hF0);

        // R4 ack clear and set-wins
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
        check("R4 ack clears", irq, 1'b0);
        @(negedge clk); int_ack = 1'b1; conv_done = 1'b1; conv_value = 12'h123;
        @(negedge clk); int_ack = 1'b0; conv_done = 1'b0;
        check("R4 set wins over ack", irq, 1'b1);
        wr(A_CTRL, 8'h01);
        @(negedge clk);
        bus_addr = A_CTRL; bus_wdata = 8'h01; bus_we = 1'b1; conv_done = 1'b1; conv_value = 12'h321;
        @(negedge clk); bus_we = 1'b0; conv_done = 1'b0;
        check("R4 set wins over write zero", irq, 1'b1);
        wr(A_CTRL, 8'h01);

        // R11 result hold
        rd(A_DHI, h);
        @(negedge clk); conv_value = 12'hABC;
        repeat (3) @(negedge clk);
        rd(A_DHI, r);
        check("R11 hold without done", r, h);
        check("R11 hold value", r, exp_hi(12'h321, 1'b0));

        // R10 prescaler phase
        for (int d = 0; d < 4; d++) begin
            int n;
            n = 1 << d;
            @(negedge clk);
            bus_addr = A_CTRL; bus_wdata = {6'b100000, 2'(d)}; bus_we = 1'b1;
            @(negedge clk);
            bus_we = 1'b0;
            for (int k = 0; k < 16; k++) begin
                #1;
                check("R10 clk enable", conv_clk_en, ((k % n) == n - 1));
                @(negedge clk);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule